// File: doc/BRIEF.md
# Banked Split-Write Color Palette

This block is a 256-entry color lookup table that drives a 24-bit RGB pixel stream. Each entry holds 8 bits per channel, split into a high nibble and a low nibble. Software fills the table through a narrow write port that carries 12 bits of color per write, one nibble for each of red, green and blue. A small control register decides where those writes land and which half they update. It holds a bank number that selects one of eight groups of 32 entries, plus a half-select bit. When the half-select bit is clear, a write sets the high nibbles and also copies the same nibbles into the low half. This lets software that knows only about 12-bit color still get full, evenly spread 24-bit colors. When the bit is set, a write refines only the low nibbles.

On the display side the block takes one 8-bit pixel index per clock and returns the looked-up color one clock later. In dual-playfield mode, when playfield 2 has priority, a programmable power-of-two offset from the control register is added to the index. Border pixels show entry 0. When enhanced mode is enabled and border blanking is set, they show black instead. The border and blank flags come out delayed by the same clock as the color, so they stay aligned with it.

Top module: `bankpal_top`

## Requirements
- R1: After reset every entry reads as 0x000000, and the control register reads 0x0018 (offset code 3, every other field 0).
- R2: Control register layout: bank in [2:0], offset code in [5:3], half-select in [6], border-blank enable in [7]. A write stores these fields. Bits [15:8] are reserved: they are stored as 0 and always read back as 0.
- R3: A color write targets the entry at address {bank, col_idx}, where col_idx is 5 bits. No other entry changes.
- R4: With half-select 0, a write of {R,G,B} (R in [11:8], G in [7:4], B in [3:0]) sets both nibbles of every channel to the written nibble. Red becomes {R,R}, and so on.
- R5: With half-select 1, a write sets only the low nibble of each channel. The high nibbles keep their old values.
- R6: When dual_pf and pf2_pri are both 1 and border is 0, the lookup address is (pix_idx + offset) mod 256. The offset codes 0..7 give 0, 2, 4, 8, 16, 32, 64 and 128.
- R7: When dual_pf or pf2_pri is 0, the offset is not applied and the lookup address is pix_idx.
- R8: A border pixel shows entry 0, with no offset applied. It shows 0x000000 only when enh_en is 1 and border-blank enable is 1.
- R9: rgb_out reflects the inputs one clock earlier. border_out and blank_out equal border and blank_in delayed by one clock.
- R10: When a write and a lookup hit the same entry in the same cycle, that cycle's output shows the old contents, and the next lookup shows the new contents.
- R11: Output channel packing: rgb_out[23:16] is red, [15:8] is green and [7:0] is blue. Within each channel the high nibble comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register readback |
| col_we | input | 1 | Color write strobe |
| col_idx | input | 5 | Entry index within the selected bank |
| col_wdata | input | 12 | Color nibbles {R,G,B} |
| enh_en | input | 1 | Enhanced-mode enable (gates border blanking) |
| pix_idx | input | 8 | Pixel color index |
| pf2_pri | input | 1 | Playfield 2 has display priority |
| dual_pf | input | 1 | Dual-playfield mode |
| border | input | 1 | Pixel lies in the border area |
| blank_in | input | 1 | Blank flag travelling with the pixel |
| rgb_out | output | 24 | Looked-up color |
| border_out | output | 1 | Border flag aligned with rgb_out |
| blank_out | output | 1 | Blank flag aligned with rgb_out |

## Verification
A palette write and a pixel lookup can address the same entry in the same clock. The bench provokes this by raising the write strobe and presenting the matching pixel index on the same falling edge. It then reads the output twice. The first sample must carry the entry's old color and the second the new one, which proves the read path samples storage before the write commits. The border override and the playfield-2 offset can also coincide. The bench drives a border pixel in dual-playfield mode with priority set, and expects entry 0 or black rather than an offset entry.

// File: rtl/bankpal_pkg.sv
package bankpal_pkg;

    localparam int CTL_W      = 16;
    localparam int BANK_W     = 3;
    localparam int OFS_W      = 3;
    localparam int SLOT_W     = 5;
    localparam int NIB_W      = 4;
    localparam int CHAN_N     = 3;
    localparam int IDX_W      = BANK_W + SLOT_W;
    localparam int HALF_W     = NIB_W * CHAN_N;
    localparam int RGB_W      = 2 * HALF_W;

    // field positions in the control word
    localparam int BANK_LSB   = 0;
    localparam int OFS_LSB    = 3;
    localparam int LOSEL_BIT  = 6;
    localparam int BBLANK_BIT = 7;
    localparam int USED_W     = 8;

    localparam logic [OFS_W-1:0] OFS_RESET = 3'b011;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  ofs;
        logic              lo_sel;
        logic              bdr_blank;
    } ctl_t;

    typedef struct packed {
        logic border;
        logic blank;
        logic black;
    } pipe_t;

endpackage

// File: rtl/bankpal_ctl.sv
module bankpal_ctl
    import bankpal_pkg::*;
#(
    parameter int DATA_W = CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - USED_W;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            ctl_d.bank      = wdata[BANK_LSB +: BANK_W];
            ctl_d.ofs       = wdata[OFS_LSB +: OFS_W];
            ctl_d.lo_sel    = wdata[LOSEL_BIT];
            ctl_d.bdr_blank = wdata[BBLANK_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{bank: '0, ofs: OFS_RESET, lo_sel: 1'b0, bdr_blank: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl   = ctl_q;
    assign rdata = {{PAD_W{1'b0}}, ctl_q.bdr_blank, ctl_q.lo_sel, ctl_q.ofs, ctl_q.bank};

    // a write is visible in the stored fields on the next clock
    assert_ctl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ctl.bank == $past(wdata[BANK_LSB +: BANK_W])) &&
               (ctl.ofs  == $past(wdata[OFS_LSB +: OFS_W])));

    // without a write the register holds
    assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));

endmodule

// File: rtl/bankpal_idx.sv
module bankpal_idx
    import bankpal_pkg::*;
#(
    parameter int AW = IDX_W,
    parameter int OW = OFS_W
) (
    input  logic [AW-1:0] pix_idx,
    input  logic          pf2_pri,
    input  logic          dual_pf,
    input  logic          border,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] eff_idx
);

    logic [AW-1:0] step;

    // code 0 means no offset, code k>0 means 2**k
    always_comb begin
        step = '0;
        if (ofs != '0) begin
            step = AW'(1) << ofs;
        end
    end

    always_comb begin
        if (border) begin
            eff_idx = '0;
        end else if (dual_pf && pf2_pri) begin
            eff_idx = pix_idx + step;
        end else begin
            eff_idx = pix_idx;
        end
    end

endmodule

// File: rtl/bankpal_mem.sv
module bankpal_mem
    import bankpal_pkg::*;
#(
    parameter int ADDR_W = IDX_W,
    parameter int NW     = NIB_W,
    parameter int CH     = CHAN_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 lo_only,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [NW*CH-1:0]     wdata,
    input  logic [ADDR_W-1:0]    raddr,
    output logic [2*NW*CH-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int HW    = NW * CH;
    localparam int EW    = 2 * HW;

    typedef struct packed {
        logic [DEPTH-1:0][HW-1:0] hi;
        logic [DEPTH-1:0][HW-1:0] lo;
        logic [EW-1:0]            rd;
    } mem_st_t;

    mem_st_t s_d, s_q;
    logic [HW-1:0] hi_rd, lo_rd;
    logic [EW-1:0] merged;

    assign hi_rd = s_q.hi[raddr];
    assign lo_rd = s_q.lo[raddr];

    // interleave halves so every channel is {high nibble, low nibble}
    for (genvar c = 0; c < CH; c++) begin : g_chan
        assign merged[(2*c+2)*NW-1 -: 2*NW] = {hi_rd[(c+1)*NW-1 -: NW], lo_rd[(c+1)*NW-1 -: NW]};
    end

    always_comb begin
        s_d    = s_q;
        s_d.rd = merged;   // read sees storage before this cycle's write
        if (we) begin
            s_d.lo[waddr] = wdata;
            if (!lo_only) begin
                s_d.hi[waddr] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rd;

    // full write: both halves take the written nibbles
    assert_full_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !lo_only) |=> (s_q.hi[$past(waddr)] == $past(wdata)) &&
                             (s_q.lo[$past(waddr)] == $past(wdata)));

    // low-only write leaves the high half alone
    assert_lo_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lo_only) |=> (s_q.hi[$past(waddr)] == $past(s_q.hi[waddr])) &&
                            (s_q.lo[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/bankpal_top.sv
module bankpal_top
    import bankpal_pkg::*;
#(
    parameter int CW = CTL_W,
    parameter int AW = IDX_W,
    parameter int SW = SLOT_W,
    parameter int BW = BANK_W,
    parameter int NW = NIB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic [CW-1:0]      ctl_wdata,
    output logic [CW-1:0]      ctl_rdata,
    input  logic               col_we,
    input  logic [SW-1:0]      col_idx,
    input  logic [3*NW-1:0]    col_wdata,
    input  logic               enh_en,
    input  logic [AW-1:0]      pix_idx,
    input  logic               pf2_pri,
    input  logic               dual_pf,
    input  logic               border,
    input  logic               blank_in,
    output logic [6*NW-1:0]    rgb_out,
    output logic               border_out,
    output logic               blank_out
);

    localparam int EW = 6 * NW;

    ctl_t          ctl;
    logic [AW-1:0] eff_idx;
    logic [AW-1:0] waddr;
    logic [EW-1:0] mem_rd;
    pipe_t         pipe_d, pipe_q;

    bankpal_ctl #(.DATA_W(CW)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl),
        .rdata (ctl_rdata)
    );

    bankpal_idx #(.AW(AW), .OW(OFS_W)) u_idx (
        .pix_idx (pix_idx),
        .pf2_pri (pf2_pri),
        .dual_pf (dual_pf),
        .border  (border),
        .ofs     (ctl.ofs),
        .eff_idx (eff_idx)
    );

    assign waddr = {ctl.bank, col_idx};

    bankpal_mem #(.ADDR_W(AW), .NW(NW), .CH(3)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (col_we),
        .lo_only (ctl.lo_sel),
        .waddr   (waddr),
        .wdata   (col_wdata),
        .raddr   (eff_idx),
        .rdata   (mem_rd)
    );

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.border = border;
        pipe_d.blank  = blank_in;
        pipe_d.black  = border && enh_en && ctl.bdr_blank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rgb_out    = pipe_q.black ? '0 : mem_rd;
    assign border_out = pipe_q.border;
    assign blank_out  = pipe_q.blank;

    // blanked border pixels come out black one clock later
    assert_border_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (border && enh_en && ctl.bdr_blank) |=> (rgb_out == '0));

    // border flag travels with a single clock of delay
    assert_border_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        border |=> border_out);

    assert_blank_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_in |=> !blank_out);

endmodule

// File: tb/sim_bankpal_top.sv
module sim_bankpal_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        col_we = 1'b0;
    logic [4:0]  col_idx = '0;
    logic [11:0] col_wdata = '0;
    logic        enh_en = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic        pf2_pri = 1'b0;
    logic        dual_pf = 1'b0;
    logic        border = 1'b0;
    logic        blank_in = 1'b0;
    logic [23:0] rgb_out;
    logic        border_out;
    logic        blank_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the table and of the control fields
    logic [11:0] hi_m [256];
    logic [11:0] lo_m [256];
    logic [2:0]  m_bank;
    logic [2:0]  m_ofs;
    logic        m_lo;
    logic        m_bb;

    always #(CLK_PERIOD/2) clk = ~clk;

    bankpal_top u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .col_we(col_we), .col_idx(col_idx),
        .col_wdata(col_wdata), .enh_en(enh_en), .pix_idx(pix_idx),
        .pf2_pri(pf2_pri), .dual_pf(dual_pf), .border(border),
        .blank_in(blank_in), .rgb_out(rgb_out), .border_out(border_out),
        .blank_out(blank_out)
    );

    function automatic logic [23:0] exp_rgb(input int i);
        logic [11:0] h, l;
        h = hi_m[i];
        l = lo_m[i];
        return {h[11:8], l[11:8], h[7:4], l[7:4], h[3:0], l[3:0]};
    endfunction

    function automatic logic [7:0] step_of(input logic [2:0] c);
        return (c == 3'd0) ? 8'd0 : (8'd1 << c);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr_ctl(input logic [2:0] bank, input logic [2:0] ofs,
                          input logic lo, input logic bb, input logic [7:0] junk);
        ctl_we    = 1'b1;
        ctl_wdata = {junk, bb, lo, ofs, bank};
        @(negedge clk);
        ctl_we = 1'b0;
        m_bank = bank; m_ofs = ofs; m_lo = lo; m_bb = bb;
    endtask

    task automatic wr_col(input logic [4:0] idx, input logic [11:0] d);
        int a;
        col_we = 1'b1; col_idx = idx; col_wdata = d;
        @(negedge clk);
        col_we = 1'b0;
        a = {m_bank, idx};
        lo_m[a] = d;
        if (!m_lo) hi_m[a] = d;
    endtask

    task automatic look(input string req, input logic [7:0] p, input logic dp,
                        input logic pr, input logic bd, input logic en,
                        input logic [23:0] expv);
        pix_idx = p; dual_pf = dp; pf2_pri = pr; border = bd; enh_en = en;
        @(negedge clk);
        chk(req, {8'h0, rgb_out}, {8'h0, expv});
        border = 1'b0; dual_pf = 1'b0; pf2_pri = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ctl default", {16'h0, ctl_rdata}, 32'h0018);
        look("R1 entry 0 clear", 8'd0, 0, 0, 0, 0, 24'h0);
        look("R1 entry 255 clear", 8'd255, 0, 0, 0, 0, 24'h0);
    endtask

    task automatic t_ctl();
        wr_ctl(3'd7, 3'd7, 1'b1, 1'b1, 8'hFF);
        chk("R2 reserved read 0", {16'h0, ctl_rdata}, 32'h00FF);
        wr_ctl(3'd2, 3'd5, 1'b0, 1'b1, 8'hA5);
        chk("R2 fields stored", {16'h0, ctl_rdata}, {24'h0, 1'b1, 1'b0, 3'd5, 3'd2});
    endtask

    task automatic t_fill();
        for (int b = 0; b < 8; b++) begin
            wr_ctl(3'(b), 3'd3, 1'b0, 1'b0, 8'h00);
            for (int s = 0; s < 32; s++) begin
                logic [7:0] i;
                i = 8'(b*32 + s);
                wr_col(5'(s), {i[7:4] ^ 4'hA, i[3:0], 4'h5});
            end
        end
        look("R3 R4 fill entry 0", 8'd0, 0, 0, 0, 0, 24'hAA0055);
        look("R3 R11 fill entry 0x9C", 8'h9C, 0, 0, 0, 0, 24'h33CC55);
    endtask

    task automatic t_bank();
        wr_ctl(3'd5, 3'd3, 1'b0, 1'b0, 8'h00);
        wr_col(5'd3, 12'hABC);
        look("R3 R4 bank 5 slot 3", 8'd163, 0, 0, 0, 0, 24'hAABBCC);
        look("R3 neighbour 162 intact", 8'd162, 0, 0, 0, 0, exp_rgb(162));
        look("R3 other bank slot 3", 8'd3, 0, 0, 0, 0, exp_rgb(3));
    endtask

    task automatic t_lo();
        wr_ctl(3'd5, 3'd3, 1'b1, 1'b0, 8'h00);
        wr_col(5'd3, 12'h123);
        look("R5 low only", 8'd163, 0, 0, 0, 0, 24'hA1B2C3);
        wr_ctl(3'd5, 3'd3, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_offset();
        for (int c = 0; c < 8; c++) begin
            wr_ctl(3'd0, 3'(c), 1'b0, 1'b0, 8'h00);
            look($sformatf("R6 code %0d", c), 8'd20, 1, 1, 0, 0,
                 exp_rgb(int'(8'(8'd20 + step_of(3'(c))))));
        end
        look("R6 wrap 250+128", 8'd250, 1, 1, 0, 0, exp_rgb(122));
    endtask

    task automatic t_nooffset();
        look("R7 no priority", 8'd20, 1, 0, 0, 0, exp_rgb(20));
        look("R7 single playfield", 8'd20, 0, 1, 0, 0, exp_rgb(20));
    endtask

    task automatic t_border();
        wr_ctl(3'd0, 3'd4, 1'b0, 1'b1, 8'h00);
        look("R8 blank needs enh_en", 8'd77, 0, 0, 1, 0, exp_rgb(0));
        look("R8 black border", 8'd77, 1, 1, 1, 1, 24'h0);
        wr_ctl(3'd0, 3'd4, 1'b0, 1'b0, 8'h00);
        look("R8 entry 0 border no offset", 8'd77, 1, 1, 1, 1, exp_rgb(0));
    endtask

    task automatic t_latency();
        pix_idx = 8'd40; blank_in = 1'b1; border = 1'b0;
        @(negedge clk);
        chk("R9 first pixel", {8'h0, rgb_out}, {8'h0, exp_rgb(40)});
        chk("R9 blank delayed", {31'h0, blank_out}, 32'd1);
        pix_idx = 8'd41; blank_in = 1'b0; border = 1'b1; enh_en = 1'b0;
        chk("R9 no early change", {8'h0, rgb_out}, {8'h0, exp_rgb(40)});
        @(negedge clk);
        chk("R9 border pixel", {8'h0, rgb_out}, {8'h0, exp_rgb(0)});
        chk("R9 border delayed", {31'h0, border_out}, 32'd1);
        chk("R9 blank cleared", {31'h0, blank_out}, 32'd0);
        border = 1'b0;
        @(negedge clk);
        chk("R9 border cleared", {31'h0, border_out}, 32'd0);
    endtask

    task automatic t_collide();
        logic [23:0] old_v;
        wr_ctl(3'd2, 3'd3, 1'b0, 1'b0, 8'h00);
        old_v = exp_rgb(70);
        pix_idx = 8'd70;
        col_we = 1'b1; col_idx = 5'd6; col_wdata = 12'h5E7;
        @(negedge clk);
        col_we = 1'b0;
        hi_m[70] = 12'h5E7; lo_m[70] = 12'h5E7;
        chk("R10 old value same cycle", {8'h0, rgb_out}, {8'h0, old_v});
        @(negedge clk);
        chk("R10 new value next", {8'h0, rgb_out}, 32'h0055EE77);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin hi_m[i] = '0; lo_m[i] = '0; end
        m_bank = '0; m_ofs = 3'd3; m_lo = 1'b0; m_bb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_fill();
        t_bank();
        t_lo();
        t_offset();
        t_nooffset();
        t_border();
        t_latency();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule